// File: doc/BRIEF.md
# Texel Byte Address Generator

This block turns a texel coordinate (X, Y, Z) into the byte address of that element in memory, for use by a texture fetch path. Image geometry (base address, width, height, depth, channel type code, channel count and storage layout) is captured into configuration registers when a load strobe is pulsed. The derived quantities that are costly to compute, such as the element size, the padded row pitch and the slice size, are worked out once at that point. Coordinates then stream in through a valid/ready handshake, one per cycle. Each request yields one response that carries an address, an out-of-range flag and an error flag.

Two storage layouts are supported. In the pitch layout, each row is padded up to an alignment boundary of `ALIGN_BYTES` bytes (64 by default) and the depth slices sit back to back. In the tiled layout, the image is cut into 4x4 tiles stored row-major. Inside a tile, the two low bits of the row and the two low bits of the column are interleaved, so that texels that are near each other in 2D are also near each other in memory.

The datapath has two register stages: the products are formed in the first and summed with the base in the second. Backpressure on the response side stalls both stages without dropping a request.

Top module: `texel_addr_gen`

## Requirements
- R1: Element size in bytes equals channel bytes times channel count. Type codes 0x01 and 0x08 give 1 byte per channel. Codes 0x02, 0x09 and 0x10 give 2 bytes. Codes 0x03, 0x0a and 0x20 give 4 bytes. The channel count must be 1, 2 or 4.
- R2: Any other type code or channel count makes every later response carry `rsp_err`=1 with `rsp_addr`=0. The same holds before the first configuration load.
- R3: In the pitch layout (`cfg_layout`=0), the row pitch is width × element size rounded up to the next multiple of `ALIGN_BYTES`.
- R4: In the pitch layout, the address is base + Z·height·pitch + Y·pitch + X·elemsize, taken modulo 2^ADDR_W.
- R5: In the tiled layout (`cfg_layout`=1), the element index is ((Y>>2)·(width/4) + (X>>2))·16 + {Y[1],X[1],Y[0],X[0]}. The address is base + index·elemsize + Z·ceil4(height)·width·elemsize.
- R6: In the tiled layout, a width that is not a multiple of 4 is a configuration error, and responses then behave as in R2.
- R7: `rsp_oob` is 1 exactly when X≥width, Y≥height or Z≥depth. The address is still the value computed by R4 or R5.
- R8: An accepted request produces its response with `rsp_valid` high after the second rising edge that follows acceptance. With `rsp_ready` held high, `req_ready` stays high and one request is taken every cycle.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response outputs hold steady. No request is lost, duplicated or reordered.
- R10: Geometry inputs take effect only in the cycle in which `cfg_load`=1. Changing them at other times does not alter any address.
- R11: During reset `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Capture geometry inputs and derive pitch and slice size |
| cfg_base | input | ADDR_W | Image base byte address |
| cfg_width | input | DIM_W | Image width in elements |
| cfg_height | input | DIM_W | Image height in rows |
| cfg_depth | input | DIM_W | Number of slices (1 for a 2D image) |
| cfg_fmt | input | 8 | Channel type code |
| cfg_chans | input | 3 | Channels per element |
| cfg_layout | input | 1 | 0 pitch layout, 1 tiled layout |
| req_valid | input | 1 | Coordinate request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_x | input | DIM_W | Column coordinate |
| req_y | input | DIM_W | Row coordinate |
| req_z | input | DIM_W | Slice coordinate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Downstream accepts response |
| rsp_addr | output | ADDR_W | Byte address, 0 on error |
| rsp_oob | output | 1 | Coordinate outside image |
| rsp_err | output | 1 | Configuration invalid |

## Verification
The hardest condition to reach is a stall that arrives while both pipeline stages hold different requests. Only then does the first stage have to freeze behind a stalled output stage. The stimulus reaches it by streaming full coordinate sweeps back to back while a separate process drops `rsp_ready` pseudo-randomly on about one cycle in three. Every response is compared in order against a queue of arithmetically computed expectations, and the held outputs are checked to stay unchanged across each stalled cycle.

// File: rtl/texaddr_pkg.sv
// Shared definitions for the texel address generator.
// Assumes nothing beyond standard SystemVerilog packages.
package texaddr_pkg;

    // Storage layout selector
    typedef enum logic {
        LAY_PITCH = 1'b0,
        LAY_TILED = 1'b1
    } layout_e;

    // Width of the element-size field (up to 16 bytes per element)
    localparam int EB_W = 5;

    // Tile edge in texels for the tiled layout
    localparam int TILE_EDGE = 4;

endpackage

// File: rtl/texaddr_fmt_dec.sv
// Element-size decoder.
// Maps a channel type code and a channel count to bytes per element.
// Flags an unknown code or an illegal count; elem_bytes is 0 in that case.
// Assumes element sizes are powers of two, so sizes are formed by shifting.
module texaddr_fmt_dec
    import texaddr_pkg::*;
(
    input  logic [7:0]      fmt_code,
    input  logic [2:0]      chan_cnt,
    output logic [EB_W-1:0] elem_bytes,
    output logic            bad
);

    logic [1:0] chan_lg;
    logic [1:0] cnt_lg;
    logic       fmt_bad;
    logic       cnt_bad;

    // Decode the per-channel byte size as a power-of-two exponent
    always_comb begin
        fmt_bad = 1'b0;
        case (fmt_code)
            8'h01, 8'h08:        chan_lg = 2'd0;
            8'h02, 8'h09, 8'h10: chan_lg = 2'd1;
            8'h03, 8'h0a, 8'h20: chan_lg = 2'd2;
            default: begin
                chan_lg = 2'd0;
                fmt_bad = 1'b1;
            end
        endcase
    end

    // Decode the channel count as a power-of-two exponent
    always_comb begin
        cnt_bad = 1'b0;
        case (chan_cnt)
            3'd1:    cnt_lg = 2'd0;
            3'd2:    cnt_lg = 2'd1;
            3'd4:    cnt_lg = 2'd2;
            default: begin
                cnt_lg = 2'd0;
                cnt_bad = 1'b1;
            end
        endcase
    end

    // Combine exponents into the element size
    always_comb begin
        bad        = fmt_bad | cnt_bad;
        elem_bytes = bad ? '0 : (EB_W'(1) << ({1'b0, chan_lg} + {1'b0, cnt_lg}));
    end

endmodule

// File: rtl/texaddr_geom.sv
// Geometry register file.
// On cfg_load it captures the image description and derives the row stride
// (padded pitch, or tile-row span in the tiled layout) and the slice size.
// Between loads every derived value is held, so requests never pay for it.
// Assumes ALIGN_BYTES is a power of two.
module texaddr_geom
    import texaddr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DIM_W       = 12,
    parameter int ALIGN_BYTES = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [DIM_W-1:0]  cfg_depth,
    input  logic [7:0]        cfg_fmt,
    input  logic [2:0]        cfg_chans,
    input  logic              cfg_layout,
    output logic [ADDR_W-1:0] base_q,
    output logic [DIM_W-1:0]  width_q,
    output logic [DIM_W-1:0]  height_q,
    output logic [DIM_W-1:0]  depth_q,
    output logic [EB_W-1:0]   eb_q,
    output logic              tiled_q,
    output logic [ADDR_W-1:0] stride_q,
    output logic [ADDR_W-1:0] slice_q,
    output logic              err_q
);

    localparam int ALIGN_LG = $clog2(ALIGN_BYTES);
    localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(ALIGN_BYTES - 1);

    logic [EB_W-1:0]   eb_n;
    logic              fmt_bad;
    logic [ADDR_W-1:0] row_bytes;
    logic [ADDR_W-1:0] pitch;
    logic [DIM_W:0]    h_ceil4;
    logic [ADDR_W-1:0] stride_n;
    logic [ADDR_W-1:0] slice_n;
    logic              tiled_n;
    logic              err_n;

    texaddr_fmt_dec u_dec (
        .fmt_code   (cfg_fmt),
        .chan_cnt   (cfg_chans),
        .elem_bytes (eb_n),
        .bad        (fmt_bad)
    );

    // Unpadded row size in bytes
    always_comb row_bytes = ADDR_W'(cfg_width) * ADDR_W'(eb_n);

    // Pitch rounding; only built when an alignment is actually requested
    generate
        if (ALIGN_BYTES > 1) begin : g_pad
            always_comb pitch = (row_bytes + AMASK) & ~AMASK;
        end else begin : g_nopad
            always_comb pitch = row_bytes;
        end
    endgenerate

    // Layout-specific stride, slice size and configuration error
    always_comb begin
        tiled_n = (layout_e'(cfg_layout) == LAY_TILED);
        h_ceil4 = {1'b0, cfg_height} + (DIM_W+1)'(TILE_EDGE - 1);
        h_ceil4[1:0] = 2'b00;
        if (tiled_n) begin
            stride_n = row_bytes << 2;
            slice_n  = ADDR_W'(h_ceil4) * row_bytes;
        end else begin
            stride_n = pitch;
            slice_n  = ADDR_W'(cfg_height) * pitch;
        end
        err_n = fmt_bad | (tiled_n & (cfg_width[1:0] != 2'b00));
    end

    // Configuration registers, written only on the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            width_q  <= '0;
            height_q <= '0;
            depth_q  <= '0;
            eb_q     <= '0;
            tiled_q  <= 1'b0;
            stride_q <= '0;
            slice_q  <= '0;
            err_q    <= 1'b1;
        end else if (cfg_load) begin
            base_q   <= cfg_base;
            width_q  <= cfg_width;
            height_q <= cfg_height;
            depth_q  <= cfg_depth;
            eb_q     <= eb_n;
            tiled_q  <= tiled_n;
            stride_q <= stride_n;
            slice_q  <= slice_n;
            err_q    <= err_n;
        end
    end

    // R1: a valid configuration always holds a power-of-two element size
    a_r1_size_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        !err_q |-> $onehot(eb_q));

    // R6: the tiled layout is never accepted with a ragged width
    a_r6_tiled_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_q && tiled_q) |-> (width_q[1:0] == 2'b00));

    generate
        if (ALIGN_BYTES > 1) begin : g_chk
            // R3: pitch is aligned and pads by less than one alignment unit
            a_r3_pitch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
                (!err_q && !tiled_q) |->
                    ((stride_q[ALIGN_LG-1:0] == '0) &&
                     ((stride_q - ADDR_W'(width_q) * ADDR_W'(eb_q)) < ADDR_W'(ALIGN_BYTES))));
        end
    endgenerate

endmodule

// File: rtl/texaddr_pipe.sv
// Two-stage address datapath.
// Stage 1 forms the row, slice and column products and the range flag.
// Stage 2 adds them to the base, and forces 0 when the configuration is invalid.
// Both stages stall together under output backpressure; an empty stage
// always refills. Base and error are carried with the request, so a request
// keeps the configuration it was accepted under.
module texaddr_pipe
    import texaddr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 12
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DIM_W-1:0]  req_x,
    input  logic [DIM_W-1:0]  req_y,
    input  logic [DIM_W-1:0]  req_z,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [DIM_W-1:0]  width_q,
    input  logic [DIM_W-1:0]  height_q,
    input  logic [DIM_W-1:0]  depth_q,
    input  logic [EB_W-1:0]   eb_q,
    input  logic              tiled_q,
    input  logic [ADDR_W-1:0] stride_q,
    input  logic [ADDR_W-1:0] slice_q,
    input  logic              err_q,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_oob,
    output logic              rsp_err
);

    localparam int XI_W = DIM_W + 2;

    logic              adv2;
    logic              adv1;
    logic              fire;
    logic [ADDR_W-1:0] y_term;
    logic [XI_W-1:0]   x_idx;
    logic              oob_n;

    logic              s1_valid;
    logic [ADDR_W-1:0] s1_row;
    logic [ADDR_W-1:0] s1_slice;
    logic [ADDR_W-1:0] s1_col;
    logic [ADDR_W-1:0] s1_base;
    logic              s1_oob;
    logic              s1_err;

    // Stage advance conditions
    always_comb begin
        adv2      = !rsp_valid || rsp_ready;
        adv1      = !s1_valid || adv2;
        req_ready = adv1;
        fire      = req_valid && adv1;
    end

    // Row term and column index, with low-bit interleave in the tiled layout
    always_comb begin
        if (tiled_q) begin
            y_term = ADDR_W'(req_y >> 2);
            x_idx  = {req_x[DIM_W-1:2], req_y[1], req_x[1], req_y[0], req_x[0]};
        end else begin
            y_term = ADDR_W'(req_y);
            x_idx  = XI_W'(req_x);
        end
        oob_n = (req_x >= width_q) || (req_y >= height_q) || (req_z >= depth_q);
    end

    // Stage 1: products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_row   <= '0;
            s1_slice <= '0;
            s1_col   <= '0;
            s1_base  <= '0;
            s1_oob   <= 1'b0;
            s1_err   <= 1'b0;
        end else if (adv1) begin
            s1_valid <= req_valid;
            if (req_valid) begin
                s1_row   <= y_term * stride_q;
                s1_slice <= ADDR_W'(req_z) * slice_q;
                s1_col   <= ADDR_W'(x_idx) * ADDR_W'(eb_q);
                s1_base  <= base_q;
                s1_oob   <= oob_n;
                s1_err   <= err_q;
            end
        end
    end

    // Stage 2: final sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_oob   <= 1'b0;
            rsp_err   <= 1'b0;
        end else if (adv2) begin
            rsp_valid <= s1_valid;
            if (s1_valid) begin
                rsp_addr <= s1_err ? '0 : (s1_base + s1_row + s1_slice + s1_col);
                rsp_oob  <= s1_oob;
                rsp_err  <= s1_err;
            end
        end
    end

    // R9: a stalled response stays put until taken
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_addr) && $stable(rsp_oob) && $stable(rsp_err)));

    // R8: the input is only refused under output backpressure
    a_r8_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (rsp_valid && !rsp_ready));

    // R8: an accepted request occupies stage 1 on the next cycle
    a_r8_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> s1_valid);

endmodule

// File: rtl/texel_addr_gen.sv
// Texel byte address generator, top level.
// Holds the geometry registers and the two-stage datapath.
// Assumes cfg_load is pulsed while no request is pending if strict
// ordering between old and new geometry is needed; a request that is
// already in flight keeps the base and error status it was accepted under.
module texel_addr_gen
    import texaddr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DIM_W       = 12,
    parameter int ALIGN_BYTES = 64
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [DIM_W-1:0]  cfg_depth,
    input  logic [7:0]        cfg_fmt,
    input  logic [2:0]        cfg_chans,
    input  logic              cfg_layout,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DIM_W-1:0]  req_x,
    input  logic [DIM_W-1:0]  req_y,
    input  logic [DIM_W-1:0]  req_z,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_oob,
    output logic              rsp_err
);

    logic [ADDR_W-1:0] base_q;
    logic [DIM_W-1:0]  width_q;
    logic [DIM_W-1:0]  height_q;
    logic [DIM_W-1:0]  depth_q;
    logic [EB_W-1:0]   eb_q;
    logic              tiled_q;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] slice_q;
    logic              err_q;

    texaddr_geom #(
        .ADDR_W      (ADDR_W),
        .DIM_W       (DIM_W),
        .ALIGN_BYTES (ALIGN_BYTES)
    ) u_geom (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_base   (cfg_base),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .cfg_depth  (cfg_depth),
        .cfg_fmt    (cfg_fmt),
        .cfg_chans  (cfg_chans),
        .cfg_layout (cfg_layout),
        .base_q     (base_q),
        .width_q    (width_q),
        .height_q   (height_q),
        .depth_q    (depth_q),
        .eb_q       (eb_q),
        .tiled_q    (tiled_q),
        .stride_q   (stride_q),
        .slice_q    (slice_q),
        .err_q      (err_q)
    );

    texaddr_pipe #(
        .ADDR_W (ADDR_W),
        .DIM_W  (DIM_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_x     (req_x),
        .req_y     (req_y),
        .req_z     (req_z),
        .base_q    (base_q),
        .width_q   (width_q),
        .height_q  (height_q),
        .depth_q   (depth_q),
        .eb_q      (eb_q),
        .tiled_q   (tiled_q),
        .stride_q  (stride_q),
        .slice_q   (slice_q),
        .err_q     (err_q),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_addr  (rsp_addr),
        .rsp_oob   (rsp_oob),
        .rsp_err   (rsp_err)
    );

    // R2: an error response never carries an address
    a_r2_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_addr == '0));

endmodule

// File: tb/sim_texel_addr_gen.sv
// Self-checking bench: coordinate sweeps over small images in both layouts,
// with expected addresses computed arithmetically.
module sim_texel_addr_gen;

    localparam int ADDR_W = 32;
    localparam int DIM_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [DIM_W-1:0]  cfg_width = '0;
    logic [DIM_W-1:0]  cfg_height = '0;
    logic [DIM_W-1:0]  cfg_depth = '0;
    logic [7:0]        cfg_fmt = '0;
    logic [2:0]        cfg_chans = '0;
    logic              cfg_layout = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [DIM_W-1:0]  req_x = '0;
    logic [DIM_W-1:0]  req_y = '0;
    logic [DIM_W-1:0]  req_z = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b1;
    logic [ADDR_W-1:0] rsp_addr;
    logic              rsp_oob;
    logic              rsp_err;

    int total = 0;
    int bad = 0;
    bit bp_mode = 1'b0;
    bit done = 1'b0;
    string tag = "R4";

    // Bench-side copy of the loaded geometry
    longint m_base, m_w, m_h, m_d;
    int     m_fmt, m_ch;
    bit     m_tiled;

    logic [33:0] exp_q[$];

    always #2 clk = ~clk;

    texel_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_depth(cfg_depth),
        .cfg_fmt(cfg_fmt), .cfg_chans(cfg_chans), .cfg_layout(cfg_layout),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_y(req_y), .req_z(req_z),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_oob(rsp_oob), .rsp_err(rsp_err)
    );

    function automatic void check(bit ok, string req, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endfunction

    // Expected {err, oob, addr} from the requirements
    function automatic logic [33:0] model(longint x, longint y, longint z);
        longint cb, ch, eb, pitch, a, idx, intra, h4;
        bit err, oob;
        case (m_fmt)
            'h01, 'h08:        cb = 1;
            'h02, 'h09, 'h10:  cb = 2;
            'h03, 'h0a, 'h20:  cb = 4;
            default:           cb = 0;
        endcase
        ch  = (m_ch == 1 || m_ch == 2 || m_ch == 4) ? m_ch : 0;
        eb  = cb * ch;
        err = (eb == 0) || (m_tiled && (m_w % 4 != 0));
        oob = (x >= m_w) || (y >= m_h) || (z >= m_d);
        if (m_tiled) begin
            intra = ((y % 4) / 2) * 8 + ((x % 4) / 2) * 4 + (y % 2) * 2 + (x % 2);
            idx   = ((y / 4) * (m_w / 4) + (x / 4)) * 16 + intra;
            h4    = ((m_h + 3) / 4) * 4;
            a     = m_base + idx * eb + z * h4 * m_w * eb;
        end else begin
            pitch = ((m_w * eb + 63) / 64) * 64;
            a     = m_base + z * m_h * pitch + y * pitch + x * eb;
        end
        if (err) a = 0;
        return {err, oob, a[31:0]};
    endfunction

    // Response ready: always high, or pseudo-random in backpressure mode
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rsp_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
        end
    end

    // Response monitor: in-order comparison and stall stability (R9)
    initial begin
        bit          prev_stall = 1'b0;
        logic [33:0] prev_out = '0;
        logic [33:0] e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (prev_stall)
                    check(rsp_valid && ({rsp_err, rsp_oob, rsp_addr} == prev_out),
                          "R9 stall hold", {rsp_valid, rsp_err, rsp_oob, rsp_addr},
                          {1'b1, prev_out});
                prev_stall = rsp_valid && !rsp_ready;
                prev_out   = {rsp_err, rsp_oob, rsp_addr};
                if (rsp_valid && rsp_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 extra response", rsp_addr, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(rsp_addr == e[31:0], tag, rsp_addr, e[31:0]);
                        check(rsp_oob == e[32], "R7 oob flag", rsp_oob, e[32]);
                        check(rsp_err == e[33], "R2/R6 err flag", rsp_err, e[33]);
                    end
                end
            end
        end
    end

    task automatic load_cfg(longint base, longint w, longint h, longint d,
                            int fmt, int ch, bit tiled);
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
        cfg_base = base[31:0]; cfg_width = w[DIM_W-1:0]; cfg_height = h[DIM_W-1:0];
        cfg_depth = d[DIM_W-1:0]; cfg_fmt = fmt[7:0]; cfg_chans = ch[2:0];
        cfg_layout = tiled; cfg_load = 1'b1;
        m_base = base; m_w = w; m_h = h; m_d = d; m_fmt = fmt; m_ch = ch; m_tiled = tiled;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic send(longint x, longint y, longint z);
        @(negedge clk);
        req_valid = 1'b1;
        req_x = x[DIM_W-1:0]; req_y = y[DIM_W-1:0]; req_z = z[DIM_W-1:0];
        #1;
        if (!bp_mode)
            check(req_ready, "R8 full throughput", req_ready, 1);
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(x, y, z));
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic sweep();
        for (longint z = 0; z <= m_d; z++)
            for (longint y = 0; y <= m_h; y++)
                for (longint x = 0; x <= m_w; x++)
                    send(x, y, z);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int fmts[8] = '{'h01, 'h02, 'h03, 'h08, 'h09, 'h0a, 'h10, 'h20};
        int chs[3]  = '{1, 2, 4};

        // R11: reset state
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R11 rsp_valid in reset", rsp_valid, 0);
        check(req_ready == 1'b1, "R11 req_ready in reset", req_ready, 1);
        rst_n = 1'b1;

        // R2: request before any configuration
        m_fmt = 0; m_ch = 0; m_w = 0; m_h = 0; m_d = 0; m_base = 0; m_tiled = 0;
        tag = "R2 unconfigured";
        send(0, 0, 0);

        // R1, R4: pitch layout, every type code and channel count
        foreach (fmts[i])
            foreach (chs[j]) begin
                load_cfg('h1000, 6, 3, 2, fmts[i], chs[j], 1'b0);
                tag = "R1/R4 pitch addr";
                sweep();
            end

        // R5: tiled layout, every element size
        foreach (fmts[i])
            foreach (chs[j]) begin
                load_cfg('h20000, 8, 5, 2, fmts[i], chs[j], 1'b1);
                tag = "R5 tiled addr";
                sweep();
            end

        // R3: pitch padding at and across alignment boundaries
        tag = "R3 padded pitch";
        load_cfg('h40, 37, 4, 2, 'h20, 4, 1'b0);
        send(0, 1, 0); send(36, 3, 1); send(5, 2, 1);
        load_cfg('h0, 64, 4, 1, 'h01, 1, 1'b0);
        send(0, 1, 0); send(63, 3, 0);
        load_cfg('h0, 65, 4, 1, 'h01, 1, 1'b0);
        send(0, 1, 0); send(64, 2, 0);
        load_cfg('hFFFF_FF00, 100, 50, 3, 'h09, 2, 1'b0);
        send(99, 49, 2); send(100, 50, 3);

        // R2: bad codes and counts; R6: ragged tiled width
        tag = "R2 bad format";
        load_cfg('h1000, 6, 3, 1, 'h00, 1, 1'b0); send(1, 1, 0);
        load_cfg('h1000, 6, 3, 1, 'h04, 2, 1'b0); send(1, 1, 0);
        load_cfg('h1000, 6, 3, 1, 'h11, 4, 1'b0); send(7, 1, 0);
        tag = "R2 bad count";
        load_cfg('h1000, 6, 3, 1, 'h01, 0, 1'b0); send(1, 1, 0);
        load_cfg('h1000, 6, 3, 1, 'h01, 3, 1'b0); send(1, 1, 0);
        load_cfg('h1000, 6, 3, 1, 'h20, 5, 1'b0); send(1, 1, 0);
        tag = "R6 tiled width";
        load_cfg('h1000, 6, 4, 1, 'h01, 1, 1'b1); send(2, 2, 0); send(5, 3, 0);

        // R8: latency of two edges from an idle pipeline
        load_cfg('h300, 8, 8, 1, 'h02, 1, 1'b0);
        tag = "R8 latency addr";
        send(3, 2, 0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R8 not valid after one edge", rsp_valid, 0);
        @(negedge clk);
        check(rsp_valid == 1'b1, "R8 valid after two edges", rsp_valid, 1);

        // R10: geometry inputs ignored without the load strobe
        load_cfg('h5000, 8, 4, 2, 'h03, 2, 1'b0);
        cfg_base = 'h9999; cfg_width = 20; cfg_height = 9; cfg_fmt = 'h01;
        cfg_chans = 1; cfg_layout = 1'b1;
        tag = "R10 config held";
        sweep();

        // R9: backpressure over both layouts
        bp_mode = 1'b1;
        load_cfg('h7700, 6, 3, 2, 'h10, 4, 1'b0);
        tag = "R9 pitch under stall";
        sweep();
        load_cfg('h8800, 12, 6, 2, 'h0a, 2, 1'b1);
        tag = "R9 tiled under stall";
        sweep();
        bp_mode = 1'b0;

        wait (exp_q.size() == 0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule